// File: doc/BRIEF.md
# NAND Parameter Page Decoder with On-Die ECC Control

This block fetches the self-description page of an attached NAND flash device through a simple byte-operation port. It also decodes that page into geometry and capability registers. On a start pulse it sends the fetch command and waits on the device status. It then switches the device back to data output and streams the table in. While the bytes arrive, each field is captured at its fixed byte position. No copy of the page is kept.

After the last byte, the block rejects a page that reads back as all 0xFF. Otherwise it applies a fixed rule to the captured manufacturer, correction-strength and model bytes. If the rule matches, it sends a feature-write sequence that turns the device's internal ECC on or off, as the caller asked at start. The flags and the decoded fields appear in the same cycle as a one-cycle completion pulse.

Each operation on the byte port is presented with a kind code and a byte. It is held until the device side acknowledges it. A read operation returns its byte on the acknowledge cycle.

Top module: `onfi_pp_reader`

## Requirements
- R1: Out of reset, busy_o, done_o, valid_o, err_o, ecc_en_o, nand_req_o and every field output are 0.
- R2: After start_i, the port issues, in order: command 0xEC, address 0x00, command 0x70, then status reads until a returned byte has bit 6 set, then command 0x00, then exactly TBL_LEN reads. Kind codes are 0 command, 1 address, 2 data write, 3 data read.
- R3: If POLL_MAX status reads in a row all return bit 6 clear, the block ends with err_o=1 and valid_o=0, and issues no further operation.
- R4: If every table byte is 0xFF, the block ends with err_o=1 and valid_o=0, all field outputs are 0, and no feature write is issued.
- R5: When valid_o=1, the fields are decoded little-endian (lowest offset in the least significant byte): model = byte 49, manufacturer = byte 64, page bytes = 80..83, spare bytes = 84..85, pages per block = 92..95, blocks per LUN = 96..99, LUN count = byte 100, ECC bits = byte 112. Other bytes have no effect on any field.
- R6: bus16_o equals bit 0 of table byte 6 when valid_o=1.
- R7: The device is eligible for on-die ECC only when (manufacturer & 0x2C) == 0x2C, ECC bits == 4, and the model byte is 0x31, 0x32 or 0x34.
- R8: For an eligible device with ecc_on_i=1 at start, the table read is followed by command 0xEF, address 0x90 and data writes 0x08, 0x00, 0x00, 0x00, and the block ends with ecc_en_o=1.
- R9: For an eligible device with ecc_on_i=0 at start, the same sequence is sent with four 0x00 data bytes, and the block ends with ecc_en_o=0.
- R10: For a valid but ineligible page, no operation follows the table read, and the block ends with valid_o=1, err_o=0 and ecc_en_o=0.
- R11: nand_req_o stays high with a stable kind and byte until nand_ack_i, and each acknowledged cycle completes exactly one operation.
- R12: done_o is a single-cycle pulse, raised in the same cycle the final flags and fields appear. start_i while busy_o=1 has no effect on the operation stream.
- R13: One cycle after an accepted start, busy_o=1 and valid_o, err_o and ecc_en_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a fetch when idle |
| ecc_on_i | input | 1 | Requested on-die ECC state, sampled at start |
| nand_req_o | output | 1 | Operation pending on the byte port |
| nand_kind_o | output | 2 | Operation kind: 0 cmd, 1 addr, 2 write, 3 read |
| nand_wdata_o | output | 8 | Command, address or write byte |
| nand_ack_i | input | 1 | Operation completes this cycle |
| nand_rdata_i | input | 8 | Read byte, valid with nand_ack_i on reads |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| valid_o | output | 1 | Decoded fields are valid |
| err_o | output | 1 | Blank page or status timeout |
| ecc_en_o | output | 1 | On-die ECC was switched on |
| bus16_o | output | 1 | Device data bus is 16 bits wide |
| model_o | output | 8 | Model byte |
| mfr_id_o | output | 8 | Manufacturer code |
| page_bytes_o | output | 32 | Data bytes per page |
| spare_bytes_o | output | 16 | Spare bytes per page |
| blk_pages_o | output | 32 | Pages per block |
| lun_blocks_o | output | 32 | Blocks per LUN |
| lun_cnt_o | output | 8 | Number of LUNs |
| ecc_bits_o | output | 8 | Correctable bits required |

## Verification
Each port operation is accepted on the rising edge where nand_ack_i is high. The device model in the bench raises the acknowledge half a cycle earlier and logs the operation then, so the logged stream is complete before the state moves on.

The done pulse, flags and fields follow the last accepted operation by one edge for a timeout or a feature-write finish. For a blank or ineligible page they follow by two edges, because the decision takes its own cycle. The bench therefore waits for done_o at falling edges and reads every result in that same half-cycle. It then checks one falling edge later that the pulse has dropped.

The clearing of flags on start is checked at the first falling edge after the start edge.

// File: rtl/onfi_pp_pkg.sv
package onfi_pp_pkg;

  typedef enum logic [1:0] {
    OP_CMD  = 2'd0,
    OP_ADDR = 2'd1,
    OP_WR   = 2'd2,
    OP_RD   = 2'd3
  } op_kind_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RPP_CMD, S_RPP_ADR, S_ST_CMD, S_ST_RD, S_RD_CMD,
    S_TBL, S_DECIDE, S_SF_CMD, S_SF_ADR, S_SF_DAT
  } seq_state_e;

  localparam logic [7:0] CMD_PARAM  = 8'hEC;
  localparam logic [7:0] CMD_STATUS = 8'h70;
  localparam logic [7:0] CMD_READ   = 8'h00;
  localparam logic [7:0] CMD_SETF   = 8'hEF;
  localparam logic [7:0] FEAT_ECC   = 8'h90;
  localparam logic [7:0] ECC_ON_VAL = 8'h08;
  localparam logic [7:0] BLANK_BYTE = 8'hFF;

  // byte positions decoded from the table
  localparam int OFS_BUSW  = 6;
  localparam int OFS_MODEL = 49;
  localparam int OFS_MFR   = 64;
  localparam int OFS_PGB   = 80;
  localparam int OFS_SPB   = 84;
  localparam int OFS_PPB   = 92;
  localparam int OFS_BPL   = 96;
  localparam int OFS_LUN   = 100;
  localparam int OFS_ECC   = 112;

endpackage

// File: rtl/onfi_field_cap.sv
module onfi_field_cap #(
  parameter int OFFS  = 0,
  parameter int NB    = 1,
  parameter int IDX_W = 8,
  localparam int VW   = 8 * NB
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             stb_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       byte_i,
  output logic [VW-1:0]    val_o
);

  logic [VW-1:0] val_q;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  val_q[8*b +: 8] <= '0;
      else if (clr_i)                               val_q[8*b +: 8] <= '0;
      else if (stb_i && idx_i == IDX_W'(OFFS + b))  val_q[8*b +: 8] <= byte_i;
    end
  end

  assign val_o = val_q;

  // bytes outside this field's window leave it untouched
  p_window_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && (!stb_i || idx_i < IDX_W'(OFFS) || idx_i >= IDX_W'(OFFS + NB)))
      |=> $stable(val_o));

endmodule

// File: rtl/onfi_ecc_rule.sv
module onfi_ecc_rule #(
  parameter logic [7:0] MFR_MASK = 8'h2C,
  parameter logic [7:0] ECC_REQ  = 8'h04
) (
  input  logic [7:0] mfr_i,
  input  logic [7:0] ecc_bits_i,
  input  logic [7:0] model_i,
  output logic       elig_o
);

  logic mfr_ok, ecc_ok, model_ok;

  assign mfr_ok   = (mfr_i & MFR_MASK) == MFR_MASK;
  assign ecc_ok   = ecc_bits_i == ECC_REQ;
  assign model_ok = (model_i == 8'h31) || (model_i == 8'h32) || (model_i == 8'h34);
  assign elig_o   = mfr_ok && ecc_ok && model_ok;

endmodule

// File: rtl/onfi_seq.sv
module onfi_seq
  import onfi_pp_pkg::*;
#(
  parameter int TBL_LEN  = 256,
  parameter int POLL_MAX = 64,
  localparam int IDX_W   = $clog2(TBL_LEN),
  localparam int PW      = $clog2(POLL_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             ecc_on_i,
  input  logic             elig_i,
  output logic             req_o,
  output logic [1:0]       kind_o,
  output logic [7:0]       wdata_o,
  input  logic             ack_i,
  input  logic [7:0]       rdata_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             valid_o,
  output logic             err_o,
  output logic             ecc_en_o,
  output logic             clr_o,
  output logic             cap_stb_o,
  output logic [IDX_W-1:0] cap_idx_o
);

  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic [PW-1:0]    poll_q;
  logic [1:0]       sf_q;
  logic             ecc_on_q, nonff_q, done_q, valid_q, err_q, ecc_en_q;
  logic             fire;
  op_kind_e         kind;

  assign fire = req_o && ack_i;

  always_comb begin
    req_o   = 1'b1;
    kind    = OP_CMD;
    wdata_o = 8'h00;
    unique case (state_q)
      S_RPP_CMD: wdata_o = CMD_PARAM;
      S_RPP_ADR: kind = OP_ADDR;
      S_ST_CMD:  wdata_o = CMD_STATUS;
      S_ST_RD:   kind = OP_RD;
      S_RD_CMD:  wdata_o = CMD_READ;
      S_TBL:     kind = OP_RD;
      S_SF_CMD:  wdata_o = CMD_SETF;
      S_SF_ADR:  begin kind = OP_ADDR; wdata_o = FEAT_ECC; end
      S_SF_DAT:  begin
        kind    = OP_WR;
        wdata_o = (sf_q == 2'd0 && ecc_on_q) ? ECC_ON_VAL : 8'h00;
      end
      default:   req_o = 1'b0;
    endcase
  end

  assign kind_o = kind;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      idx_q    <= '0;
      poll_q   <= '0;
      sf_q     <= '0;
      ecc_on_q <= 1'b0;
      nonff_q  <= 1'b0;
      done_q   <= 1'b0;
      valid_q  <= 1'b0;
      err_q    <= 1'b0;
      ecc_en_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          ecc_on_q <= ecc_on_i;
          valid_q  <= 1'b0;
          err_q    <= 1'b0;
          ecc_en_q <= 1'b0;
          nonff_q  <= 1'b0;
          idx_q    <= '0;
          poll_q   <= '0;
          sf_q     <= '0;
          state_q  <= S_RPP_CMD;
        end
        S_RPP_CMD: if (fire) state_q <= S_RPP_ADR;
        S_RPP_ADR: if (fire) state_q <= S_ST_CMD;
        S_ST_CMD:  if (fire) state_q <= S_ST_RD;
        S_ST_RD: if (fire) begin
          if (rdata_i[6]) begin
            state_q <= S_RD_CMD;
          end else if (poll_q == PW'(POLL_MAX - 1)) begin
            err_q   <= 1'b1;
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            poll_q <= poll_q + 1'b1;
          end
        end
        S_RD_CMD: if (fire) state_q <= S_TBL;
        S_TBL: if (fire) begin
          if (rdata_i != BLANK_BYTE) nonff_q <= 1'b1;
          if (idx_q == IDX_W'(TBL_LEN - 1)) state_q <= S_DECIDE;
          else                              idx_q   <= idx_q + 1'b1;
        end
        S_DECIDE: begin
          if (!nonff_q) begin
            err_q   <= 1'b1;
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else if (elig_i) begin
            state_q <= S_SF_CMD;
          end else begin
            valid_q <= 1'b1;
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        S_SF_CMD: if (fire) state_q <= S_SF_ADR;
        S_SF_ADR: if (fire) state_q <= S_SF_DAT;
        S_SF_DAT: if (fire) begin
          if (sf_q == 2'd3) begin
            valid_q  <= 1'b1;
            ecc_en_q <= ecc_on_q;
            done_q   <= 1'b1;
            state_q  <= S_IDLE;
          end else begin
            sf_q <= sf_q + 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o    = state_q != S_IDLE;
  assign done_o    = done_q;
  assign valid_o   = valid_q;
  assign err_o     = err_q;
  assign ecc_en_o  = ecc_en_q;
  assign clr_o     = start_i && state_q == S_IDLE;
  assign cap_stb_o = fire && state_q == S_TBL;
  assign cap_idx_o = idx_q;

  p_req_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> (req_o && $stable(kind_o) && $stable(wdata_o)));
  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !req_o);
  p_done_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_flag_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && err_o));
  p_ecc_needs_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecc_en_o |-> valid_o);
  p_start_clears_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !valid_o && !err_o && !ecc_en_o));

endmodule

// File: rtl/onfi_pp_reader.sv
module onfi_pp_reader
  import onfi_pp_pkg::*;
#(
  parameter int TBL_LEN  = 256,
  parameter int POLL_MAX = 64,
  localparam int IDX_W   = $clog2(TBL_LEN)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        ecc_on_i,
  output logic        nand_req_o,
  output logic [1:0]  nand_kind_o,
  output logic [7:0]  nand_wdata_o,
  input  logic        nand_ack_i,
  input  logic [7:0]  nand_rdata_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        valid_o,
  output logic        err_o,
  output logic        ecc_en_o,
  output logic        bus16_o,
  output logic [7:0]  model_o,
  output logic [7:0]  mfr_id_o,
  output logic [31:0] page_bytes_o,
  output logic [15:0] spare_bytes_o,
  output logic [31:0] blk_pages_o,
  output logic [31:0] lun_blocks_o,
  output logic [7:0]  lun_cnt_o,
  output logic [7:0]  ecc_bits_o
);

  logic             clr, stb, elig;
  logic [IDX_W-1:0] idx;
  logic [7:0]       busw_raw, model, mfr, luns, eccb;
  logic [31:0]      pgb, ppb, bpl;
  logic [15:0]      spb;
  logic             unused_busw;

  onfi_seq #(.TBL_LEN(TBL_LEN), .POLL_MAX(POLL_MAX)) u_seq (
    .clk_i, .rst_ni, .start_i, .ecc_on_i,
    .elig_i    (elig),
    .req_o     (nand_req_o),
    .kind_o    (nand_kind_o),
    .wdata_o   (nand_wdata_o),
    .ack_i     (nand_ack_i),
    .rdata_i   (nand_rdata_i),
    .busy_o, .done_o, .valid_o, .err_o, .ecc_en_o,
    .clr_o     (clr),
    .cap_stb_o (stb),
    .cap_idx_o (idx)
  );

  onfi_field_cap #(.OFFS(OFS_BUSW),  .NB(1), .IDX_W(IDX_W)) u_busw  (.clk_i, .rst_ni, .clr_i(clr), .stb_i(stb), .idx_i(idx), .byte_i(nand_rdata_i), .val_o(busw_raw));
  onfi_field_cap #(.OFFS(OFS_MODEL), .NB(1), .IDX_W(IDX_W)) u_model (.clk_i, .rst_ni, .clr_i(clr), .stb_i(stb), .idx_i(idx), .byte_i(nand_rdata_i), .val_o(model));
  onfi_field_cap #(.OFFS(OFS_MFR),   .NB(1), .IDX_W(IDX_W)) u_mfr   (.clk_i, .rst_ni, .clr_i(clr), .stb_i(stb), .idx_i(idx), .byte_i(nand_rdata_i), .val_o(mfr));
  onfi_field_cap #(.OFFS(OFS_PGB),   .NB(4), .IDX_W(IDX_W)) u_pgb   (.clk_i, .rst_ni, .clr_i(clr), .stb_i(stb), .idx_i(idx), .byte_i(nand_rdata_i), .val_o(pgb));
  onfi_field_cap #(.OFFS(OFS_SPB),   .NB(2), .IDX_W(IDX_W)) u_spb   (.clk_i, .rst_ni, .clr_i(clr), .stb_i(stb), .idx_i(idx), .byte_i(nand_rdata_i), .val_o(spb));
  onfi_field_cap #(.OFFS(OFS_PPB),   .NB(4), .IDX_W(IDX_W)) u_ppb   (.clk_i, .rst_ni, .clr_i(clr), .stb_i(stb), .idx_i(idx), .byte_i(nand_rdata_i), .val_o(ppb));
  onfi_field_cap #(.OFFS(OFS_BPL),   .NB(4), .IDX_W(IDX_W)) u_bpl   (.clk_i, .rst_ni, .clr_i(clr), .stb_i(stb), .idx_i(idx), .byte_i(nand_rdata_i), .val_o(bpl));
  onfi_field_cap #(.OFFS(OFS_LUN),   .NB(1), .IDX_W(IDX_W)) u_lun   (.clk_i, .rst_ni, .clr_i(clr), .stb_i(stb), .idx_i(idx), .byte_i(nand_rdata_i), .val_o(luns));
  onfi_field_cap #(.OFFS(OFS_ECC),   .NB(1), .IDX_W(IDX_W)) u_ecc   (.clk_i, .rst_ni, .clr_i(clr), .stb_i(stb), .idx_i(idx), .byte_i(nand_rdata_i), .val_o(eccb));

  onfi_ecc_rule u_rule (
    .mfr_i      (mfr),
    .ecc_bits_i (eccb),
    .model_i    (model),
    .elig_o     (elig)
  );

  assign unused_busw = ^busw_raw[7:1];

  // fields are reported only for an accepted page
  assign bus16_o       = valid_o & busw_raw[0];
  assign model_o       = valid_o ? model : '0;
  assign mfr_id_o      = valid_o ? mfr   : '0;
  assign page_bytes_o  = valid_o ? pgb   : '0;
  assign spare_bytes_o = valid_o ? spb   : '0;
  assign blk_pages_o   = valid_o ? ppb   : '0;
  assign lun_blocks_o  = valid_o ? bpl   : '0;
  assign lun_cnt_o     = valid_o ? luns  : '0;
  assign ecc_bits_o    = valid_o ? eccb  : '0;

  p_err_hides_fields_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (page_bytes_o == '0 && mfr_id_o == '0 && !bus16_o));

endmodule

// File: tb/onfi_pp_reader_tb_top.sv
`timescale 1ns/1ps
module onfi_pp_reader_tb_top;

  localparam int TBL  = 256;
  localparam int PMAX = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, ecc_on = 1'b0;
  logic req, ack = 1'b0;
  logic [1:0] kind;
  logic [7:0] wdata, rdata = 8'h00;
  logic busy, done, valid, err, ecc_en, bus16;
  logic [7:0] model, mfr, luns, eccb;
  logic [31:0] pgb, ppb, bpl;
  logic [15:0] spb;

  always #2.5 clk = ~clk;

  onfi_pp_reader #(.TBL_LEN(TBL), .POLL_MAX(PMAX)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ecc_on_i(ecc_on),
    .nand_req_o(req), .nand_kind_o(kind), .nand_wdata_o(wdata),
    .nand_ack_i(ack), .nand_rdata_i(rdata),
    .busy_o(busy), .done_o(done), .valid_o(valid), .err_o(err), .ecc_en_o(ecc_en),
    .bus16_o(bus16), .model_o(model), .mfr_id_o(mfr), .page_bytes_o(pgb),
    .spare_bytes_o(spb), .blk_pages_o(ppb), .lun_blocks_o(bpl),
    .lun_cnt_o(luns), .ecc_bits_o(eccb)
  );

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] page [TBL];
  int poll_delay = 0;
  int log_n = 0, exp_n = 0;
  logic [1:0] log_k [1024];
  logic [7:0] log_d [1024];
  logic [1:0] exp_k [1024];
  logic [7:0] exp_d [1024];

  // device model: acks at falling edges, logs every accepted operation
  int wait_c = 0, st_cnt = 0, rd_ptr = 0;
  logic [7:0] last_cmd = 8'h00;
  always @(negedge clk) begin
    if (!rst_n) begin
      ack = 1'b0;
    end else if (ack) begin
      ack = 1'b0;
      wait_c = $urandom_range(0, 2);
    end else if (req) begin
      if (wait_c > 0) wait_c--;
      else begin
        ack = 1'b1;
        if (log_n < 1024) begin log_k[log_n] = kind; log_d[log_n] = wdata; end
        log_n++;
        case (kind)
          2'd0: begin
            last_cmd = wdata;
            if (wdata == 8'h70) st_cnt = 0;
            if (wdata == 8'h00) rd_ptr = 0;
          end
          2'd3: begin
            if (last_cmd == 8'h70) begin
              rdata = (st_cnt >= poll_delay) ? 8'h40 : (8'($urandom) & 8'hBF);
              st_cnt++;
            end else begin
              rdata = page[rd_ptr % TBL];
              rd_ptr++;
            end
          end
          default: ;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 190000) begin
      errors++;
      $display("FAIL R12 watchdog: actual=%0d expected<%0d cycles", cyc, 190000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] le(input int off, input int nb);
    logic [31:0] v = '0;
    for (int b = 0; b < nb; b++) v[8*b +: 8] = page[off + b];
    return v;
  endfunction

  function automatic bit ref_elig();
    return ((page[64] & 8'h2C) == 8'h2C) && page[112] == 8'h04 &&
           (page[49] == 8'h31 || page[49] == 8'h32 || page[49] == 8'h34);
  endfunction

  function automatic bit ref_blank();
    for (int i = 0; i < TBL; i++) if (page[i] != 8'hFF) return 1'b0;
    return 1'b1;
  endfunction

  task automatic push(input logic [1:0] k, input logic [7:0] d);
    exp_k[exp_n] = k; exp_d[exp_n] = d; exp_n++;
  endtask

  task automatic fill_random();
    for (int i = 0; i < TBL; i++) page[i] = 8'($urandom);
  endtask

  task automatic make_elig(input logic [7:0] m, input logic [7:0] mdl);
    page[64] = m; page[112] = 8'h04; page[49] = mdl;
  endtask

  task automatic run_case(input string name, input bit on, input int pdel, input bit midstart);
    bit tmo, blank, el, xvalid, xerr, xecc;
    int first_bad;
    tmo = pdel >= PMAX;
    blank = ref_blank();
    el = ref_elig();
    poll_delay = pdel;
    exp_n = 0;
    push(2'd0, 8'hEC); push(2'd1, 8'h00); push(2'd0, 8'h70);
    if (tmo) begin
      for (int i = 0; i < PMAX; i++) push(2'd3, 8'h00);
    end else begin
      for (int i = 0; i <= pdel; i++) push(2'd3, 8'h00);
      push(2'd0, 8'h00);
      for (int i = 0; i < TBL; i++) push(2'd3, 8'h00);
      if (!blank && el) begin
        push(2'd0, 8'hEF); push(2'd1, 8'h90);
        push(2'd2, on ? 8'h08 : 8'h00);
        push(2'd2, 8'h00); push(2'd2, 8'h00); push(2'd2, 8'h00);
      end
    end
    xerr = tmo || blank;
    xvalid = !xerr;
    xecc = xvalid && el && on;

    @(negedge clk);
    log_n = 0;
    start = 1'b1; ecc_on = on;
    @(negedge clk);
    start = 1'b0; ecc_on = ~on;
    check(busy && !valid && !err && !ecc_en, "R13", {name, " start clears"},
          {busy, valid, err, ecc_en}, 4'b1000);
    if (midstart) begin
      repeat (25) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    while (!done) @(negedge clk);

    first_bad = -1;
    for (int i = 0; i < exp_n && i < log_n; i++)
      if (first_bad < 0 && (log_k[i] != exp_k[i] || (exp_k[i] != 2'd3 && log_d[i] != exp_d[i])))
        first_bad = i;
    check(log_n == exp_n, tmo ? "R3" : (el && !blank ? (on ? "R8" : "R9") : "R2"),
          {name, " op count"}, log_n, exp_n);
    check(first_bad < 0, midstart ? "R12" : "R2", {name, " op stream first mismatch"},
          first_bad < 0 ? 0 : {log_k[first_bad], log_d[first_bad]},
          first_bad < 0 ? 0 : {exp_k[first_bad], exp_d[first_bad]});
    check(err == xerr, tmo ? "R3" : "R4", {name, " err"}, err, xerr);
    check(valid == xvalid, "R10", {name, " valid"}, valid, xvalid);
    check(ecc_en == xecc, on ? "R8" : "R9", {name, " ecc_en"}, ecc_en, xecc);
    if (xvalid) begin
      check(bus16 == page[6][0], "R6", {name, " bus16"}, bus16, page[6][0]);
      check(model == page[49] && mfr == page[64], "R5", {name, " model/mfr"},
            {model, mfr}, {page[49], page[64]});
      check(pgb == le(80, 4), "R5", {name, " page bytes"}, pgb, le(80, 4));
      check(spb == le(84, 2), "R5", {name, " spare bytes"}, spb, le(84, 2));
      check(ppb == le(92, 4) && bpl == le(96, 4), "R5", {name, " block geometry"},
            {ppb, bpl}, {le(92, 4), le(96, 4)});
      check(luns == page[100] && eccb == page[112], "R5", {name, " lun/ecc"},
            {luns, eccb}, {page[100], page[112]});
      check(el || !ecc_en, "R7", {name, " eligibility"}, ecc_en, 0);
    end else begin
      check(pgb == 0 && mfr == 0 && spb == 0 && !bus16, "R4", {name, " fields hidden"},
            pgb, 0);
    end
    @(negedge clk);
    check(!done && !busy, "R12", {name, " done pulse"}, {done, busy}, 0);
  endtask

  initial begin
    void'($urandom(32'h0EC5_1A7B));
    repeat (3) @(negedge clk);
    check(!busy && !done && !valid && !err && !ecc_en && !req && pgb == 0 && mfr == 0,
          "R1", "reset state", {busy, done, valid, err, ecc_en, req}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    fill_random(); make_elig(8'h2C, 8'h32);
    run_case("elig_on", 1'b1, 3, 1'b1);
    fill_random(); make_elig(8'h2C, 8'h31);
    run_case("elig_off", 1'b0, 0, 1'b0);
    fill_random(); make_elig(8'hEC, 8'h34);
    run_case("mfr_superset", 1'b1, 1, 1'b0);
    fill_random(); make_elig(8'h2C, 8'h32); page[112] = 8'h08;
    run_case("ecc8_inelig_R7", 1'b1, 2, 1'b0);
    fill_random(); make_elig(8'h2C, 8'h33);
    run_case("model3_inelig_R7", 1'b1, 0, 1'b0);
    fill_random(); make_elig(8'h28, 8'h32);
    run_case("mfr_bits_R7", 1'b1, 0, 1'b0);
    for (int i = 0; i < TBL; i++) page[i] = 8'hFF;
    run_case("blank", 1'b1, 1, 1'b0);
    page[TBL-1] = 8'h00;
    run_case("last_byte_only", 1'b1, 0, 1'b0);
    fill_random();
    run_case("timeout", 1'b1, PMAX + 5, 1'b0);
    fill_random(); page[6] = 8'h01; page[80] = 8'h00; page[81] = 8'h08;
    run_case("bus16", 1'b0, 0, 1'b0);
    for (int r = 0; r < 6; r++) begin
      fill_random();
      if ($urandom_range(0, 1) == 1) make_elig(8'h2C | 8'($urandom), 8'h34);
      run_case("random", 1'($urandom), $urandom_range(0, 5), 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule